// File: doc/BRIEF.md
# Reset Qualifier and Memory Access Gate

This block sits between a raw active-low reset request and an embedded memory controller. It synchronises the request, measures how long it stays asserted, and sorts each reset into one of two kinds: a power-on reset (the first reset after the power-good indicator rises) or a warm reset (any later one). Each kind has its own minimum asserted width. A reset that meets its minimum is accepted. A reset that is released too early raises a sticky error flag and keeps the memory locked until a correct reset has been accepted.

Once a reset is accepted, the block refuses memory accesses for a further recovery interval and then raises `ready`. EEPROM write strobes are masked for a lockout period that starts when power-good rises and does not depend on any reset. Flash write starts are blocked for as long as the low-supply flag is high. Each release of the reset request sends a one-cycle pulse that puts the memory back into read-array mode. Every duration is given in nanoseconds and converted to clock cycles from a clock-frequency parameter, rounding up. Power-good low is the block's own asynchronous clear. While it is low, every output is inactive.

Top module: `rst_qual_gate`

## Requirements
- R1: While `pwr_good` is low, `ready`, `eeprom_wr_enable`, `flash_wr_enable`, `mem_mode_rst` and `short_err` are all 0, and any earlier error is cleared.
- R2: The first reset after `pwr_good` rises is a power-on reset. It is accepted only if the synchronised request is sampled low on at least POR_CYC = ceil(CLK_KHZ*POR_NS/1e6) clocks. Sampling starts at the first clock after `pwr_good` rises, and the synchronizer counts as asserted from that clock. With `rst_req_n` driven between edges and held low for N rising edges after `pwr_good` rises, the number of low samples is N+2.
- R3: Every reset after an accepted one is a warm reset. It is accepted only if it is sampled low on at least WARM_CYC clocks. A request driven low for N rising edges gives exactly N low samples.
- R4: After an accepted release, `ready` rises exactly 3+HOLD_CYC rising edges after the release is applied to `rst_req_n`. This is two synchronizer stages, one decision clock and HOLD_CYC recovery clocks.
- R5: While `ready` is high, driving `rst_req_n` low makes `ready` fall on the third rising edge. It is still high after the second edge.
- R6: A release that comes before the minimum width sets `short_err` and moves the block to a fault state. `ready` stays low and `short_err` stays set until a later reset is accepted. `short_err` clears at that reset's release.
- R7: `mem_mode_rst` is high for exactly one cycle, on the third rising edge after each release of `rst_req_n`, whether the reset was accepted or too short.
- R8: `eeprom_wr_enable` is 0 until EE_CYC rising edges have passed since `pwr_good` rose, whatever resets occur. After that it equals `ready`. Resets do not restart the lockout, but a power-good cycle does.
- R9: `flash_wr_enable` equals `ready` AND NOT `vdd_low`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Supply stable; low clears the block asynchronously |
| rst_req_n | input | 1 | Raw active-low reset request, asynchronous |
| vdd_low | input | 1 | Supply below the flash write threshold |
| ready | output | 1 | Memory accesses allowed |
| eeprom_wr_enable | output | 1 | EEPROM write strobes may pass |
| flash_wr_enable | output | 1 | A flash write cycle may start |
| mem_mode_rst | output | 1 | One-cycle pulse that returns memory to read-array mode |
| short_err | output | 1 | Sticky flag for a reset released too early |

## Verification
This block contains only a few pieces of internal state: the width counter, the power-on pending flag, the recovery counter and the lockout counter. An error in any of them is visible at the ports within a few cycles of the next release.

- A width counter that counts wrongly, or a power-on flag that is set wrongly, shows up on the third edge after release as the wrong `short_err` value. The bench therefore probes each minimum width exactly at the boundary and one cycle below it.
- A recovery counter that is off by one moves the rising edge of `ready`. The bench checks `ready` on the edge before and the edge of the expected rise.
- A lockout counter that is restarted by a reset, or that is off by one, shows up on `eeprom_wr_enable` at cycle EE_CYC after power-good rises.

// File: rtl/rq_pkg.sv
package rq_pkg;

  typedef enum logic [1:0] {
    ST_ASSERT = 2'd0,
    ST_HOLD   = 2'd1,
    ST_RUN    = 2'd2,
    ST_FAULT  = 2'd3
  } rq_state_t;

  // Convert a duration in ns to clock cycles at clk_khz, rounding up, minimum one.
  function automatic int unsigned ns_to_cyc(input longint unsigned clk_khz,
                                            input longint unsigned dur_ns);
    longint unsigned c;
    c = (clk_khz * dur_ns + 64'd999_999) / 64'd1_000_000;
    if (c == 0) c = 1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/rq_sync.sv
module rq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rq_satcnt.sv
module rq_satcnt #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         at_limit
);
  assign at_limit = (q == W'(LIMIT));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                q <= '0;
    else if (clr)               q <= '0;
    else if (inc && !at_limit)  q <= q + 1'b1;
  end
endmodule

// File: rtl/rq_fsm.sv
module rq_fsm
  import rq_pkg::*;
#(
  parameter int unsigned CW       = 8,
  parameter int unsigned POR_CYC  = 100,
  parameter int unsigned WARM_CYC = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          rst_s_n,
  input  logic [CW-1:0] wcnt,
  input  logic          hold_last,
  output logic          in_hold,
  output logic          ready,
  output logic          err,
  output logic          pulse
);
  rq_state_t     state;
  logic          por_pend;
  logic [CW-1:0] need;
  logic          wide_ok;

  assign need    = por_pend ? CW'(POR_CYC) : CW'(WARM_CYC);
  assign wide_ok = (wcnt >= need);
  assign in_hold = (state == ST_HOLD);
  assign ready   = (state == ST_RUN);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state    <= ST_ASSERT;
      por_pend <= 1'b1;
      err      <= 1'b0;
      pulse    <= 1'b0;
    end else begin
      pulse <= 1'b0;
      unique case (state)
        ST_ASSERT: if (rst_s_n) begin
          pulse <= 1'b1;
          if (wide_ok) begin
            state    <= ST_HOLD;
            err      <= 1'b0;
            por_pend <= 1'b0;
          end else begin
            state <= ST_FAULT;
            err   <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (!rst_s_n)       state <= ST_ASSERT;
          else if (hold_last) state <= ST_RUN;
        end
        ST_RUN, ST_FAULT: if (!rst_s_n) state <= ST_ASSERT;
        default: state <= ST_ASSERT;
      endcase
    end
  end
endmodule

// File: rtl/rst_qual_gate.sv
module rst_qual_gate #(
  parameter int unsigned CLK_KHZ = 50_000,
  parameter int unsigned POR_NS  = 1_000_000,
  parameter int unsigned WARM_NS = 150,
  parameter int unsigned HOLD_NS = 120,
  parameter int unsigned EE_NS   = 5_000_000
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic rst_req_n,
  input  logic vdd_low,
  output logic ready,
  output logic eeprom_wr_enable,
  output logic flash_wr_enable,
  output logic mem_mode_rst,
  output logic short_err
);
  import rq_pkg::*;

  localparam int unsigned POR_CYC  = ns_to_cyc(CLK_KHZ, POR_NS);
  localparam int unsigned WARM_CYC = ns_to_cyc(CLK_KHZ, WARM_NS);
  localparam int unsigned HOLD_CYC = ns_to_cyc(CLK_KHZ, HOLD_NS);
  localparam int unsigned EE_CYC   = ns_to_cyc(CLK_KHZ, EE_NS);
  localparam int unsigned WMAX     = (POR_CYC > WARM_CYC) ? POR_CYC : WARM_CYC;
  localparam int unsigned CW       = $clog2(WMAX + 1);
  localparam int unsigned HW       = $clog2(HOLD_CYC + 1);
  localparam int unsigned EW       = $clog2(EE_CYC + 1);

  logic          rst_s_n;
  logic [CW-1:0] wcnt;
  logic          wcnt_full;
  logic [HW-1:0] hcnt;
  logic          hcnt_full;
  logic [EW-1:0] ecnt;
  logic          ee_open;
  logic          in_hold;
  logic          hold_last;

  rq_sync #(.STAGES(2)) u_sync (
    .clk(clk), .arst_n(pwr_good), .d(rst_req_n), .q(rst_s_n)
  );

  // Consecutive low samples of the synchronised request.
  rq_satcnt #(.LIMIT(WMAX)) u_width (
    .clk(clk), .arst_n(pwr_good), .clr(rst_s_n), .inc(!rst_s_n),
    .q(wcnt), .at_limit(wcnt_full)
  );

  // Recovery interval after an accepted release.
  rq_satcnt #(.LIMIT(HOLD_CYC)) u_hold (
    .clk(clk), .arst_n(pwr_good), .clr(!in_hold), .inc(in_hold),
    .q(hcnt), .at_limit(hcnt_full)
  );
  assign hold_last = (hcnt == HW'(HOLD_CYC - 1));

  // EEPROM lockout, free running from power-good only.
  rq_satcnt #(.LIMIT(EE_CYC)) u_ee (
    .clk(clk), .arst_n(pwr_good), .clr(1'b0), .inc(1'b1),
    .q(ecnt), .at_limit(ee_open)
  );

  rq_fsm #(.CW(CW), .POR_CYC(POR_CYC), .WARM_CYC(WARM_CYC)) u_fsm (
    .clk(clk), .arst_n(pwr_good), .rst_s_n(rst_s_n), .wcnt(wcnt),
    .hold_last(hold_last), .in_hold(in_hold), .ready(ready),
    .err(short_err), .pulse(mem_mode_rst)
  );

  assign eeprom_wr_enable = ready & ee_open;
  assign flash_wr_enable  = ready & ~vdd_low;
endmodule

// File: rtl/rst_qual_gate_chk.sv
module rst_qual_gate_chk #(
  parameter int unsigned EE_CYC = 1
) (
  input logic clk,
  input logic pwr_good,
  input logic vdd_low,
  input logic ready,
  input logic eeprom_wr_enable,
  input logic flash_wr_enable,
  input logic mem_mode_rst,
  input logic short_err
);
  logic [31:0] pg_cyc;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good)             pg_cyc <= '0;
    else if (pg_cyc < EE_CYC)  pg_cyc <= pg_cyc + 1;
  end

  a_r9_flash_gate: assert property (@(posedge clk) disable iff (!pwr_good)
    flash_wr_enable |-> (ready && !vdd_low));

  a_r8_ee_lockout: assert property (@(posedge clk) disable iff (!pwr_good)
    eeprom_wr_enable |-> (ready && pg_cyc >= EE_CYC));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!pwr_good)
    mem_mode_rst |=> !mem_mode_rst);

  a_r6_err_blocks: assert property (@(posedge clk) disable iff (!pwr_good)
    short_err |-> !ready);

  a_r6_err_clears_on_release: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(short_err) |-> mem_mode_rst);

  a_r4_hold_gap: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(ready) |-> !mem_mode_rst);
endmodule

bind rst_qual_gate rst_qual_gate_chk #(.EE_CYC(EE_CYC)) u_chk (
  .clk(clk), .pwr_good(pwr_good), .vdd_low(vdd_low), .ready(ready),
  .eeprom_wr_enable(eeprom_wr_enable), .flash_wr_enable(flash_wr_enable),
  .mem_mode_rst(mem_mode_rst), .short_err(short_err)
);

// File: tb/sim_rst_qual_gate.sv
module sim_rst_qual_gate;
  localparam int CLK_PERIOD = 20;
  // 50 MHz: POR 100 us -> 5000, warm 150 ns -> 8, hold 120 ns -> 6, EEPROM 400 us -> 20000
  localparam int POR_C  = 5000;
  localparam int WARM_C = 8;
  localparam int HOLD_C = 6;
  localparam int EE_C   = 20000;

  logic clk = 1'b0;
  logic pwr_good = 1'b0;
  logic rst_req_n = 1'b0;
  logic vdd_low = 1'b0;
  logic ready, eeprom_wr_enable, flash_wr_enable, mem_mode_rst, short_err;

  int n_tests = 0;
  int n_fail  = 0;
  int since_pg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_qual_gate #(.CLK_KHZ(50_000), .POR_NS(100_000), .WARM_NS(150),
                  .HOLD_NS(120), .EE_NS(400_000)) u0 (
    .clk(clk), .pwr_good(pwr_good), .rst_req_n(rst_req_n), .vdd_low(vdd_low),
    .ready(ready), .eeprom_wr_enable(eeprom_wr_enable),
    .flash_wr_enable(flash_wr_enable), .mem_mode_rst(mem_mode_rst),
    .short_err(short_err)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      since_pg++;
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic power_up(input int n_low);
    pwr_good = 1'b1;
    since_pg = 0;
    tick(n_low);
    rst_req_n = 1'b1;
  endtask

  task automatic t_reset_state();
    tick(4);
    chk("R1 ready", ready, 1'b0);
    chk("R1 eeprom", eeprom_wr_enable, 1'b0);
    chk("R1 flash", flash_wr_enable, 1'b0);
    chk("R1 pulse", mem_mode_rst, 1'b0);
    chk("R1 err", short_err, 1'b0);
  endtask

  task automatic t_por_short();
    power_up(POR_C - 3);           // POR_C-1 samples
    tick(3);
    chk("R2 short por err", short_err, 1'b1);
    chk("R7 pulse on short release", mem_mode_rst, 1'b1);
    tick(1);
    chk("R7 pulse one cycle", mem_mode_rst, 1'b0);
    tick(60);
    chk("R6 ready stays low", ready, 1'b0);
    chk("R6 err sticky", short_err, 1'b1);
    pwr_good = 1'b0;
    rst_req_n = 1'b0;
    tick(3);
    chk("R1 err cleared by power loss", short_err, 1'b0);
  endtask

  task automatic t_por_exact();
    power_up(POR_C - 2);           // exactly POR_C samples
    tick(3);
    chk("R2 exact por accepted", short_err, 1'b0);
    chk("R7 pulse on accepted release", mem_mode_rst, 1'b1);
    tick(HOLD_C - 1);
    chk("R4 ready low before hold ends", ready, 1'b0);
    tick(1);
    chk("R4 ready after hold", ready, 1'b1);
  endtask

  task automatic t_gates();
    chk("R8 eeprom locked early", eeprom_wr_enable, 1'b0);
    chk("R9 flash enabled", flash_wr_enable, 1'b1);
    vdd_low = 1'b1;
    #1;
    chk("R9 flash blocked by low supply", flash_wr_enable, 1'b0);
    chk("R9 ready unaffected", ready, 1'b1);
    vdd_low = 1'b0;
    #1;
    chk("R9 flash restored", flash_wr_enable, 1'b1);
  endtask

  task automatic warm(input int n, input logic exp_err);
    rst_req_n = 1'b0;
    tick(2);
    chk("R5 ready still high", ready, 1'b1);
    tick(1);
    chk("R5 ready falls", ready, 1'b0);
    tick(n - 3);
    rst_req_n = 1'b1;
    tick(3);
    chk("R3 warm width result", short_err, exp_err);
    chk("R7 pulse", mem_mode_rst, 1'b1);
    tick(HOLD_C - 1);
    chk("R4 ready low in hold", ready, 1'b0);
    tick(1);
    chk("R4 ready after warm", ready, !exp_err);
  endtask

  task automatic t_warm_and_recover();
    warm(WARM_C, 1'b0);
    warm(40, 1'b0);                // same width a power-on reset would reject
    // a short reset issued from a running state
    rst_req_n = 1'b0;
    tick(WARM_C - 1);
    rst_req_n = 1'b1;
    tick(3);
    chk("R3 warm one short rejected", short_err, 1'b1);
    tick(40);
    chk("R6 fault holds ready low", ready, 1'b0);
    rst_req_n = 1'b0;
    tick(WARM_C);
    rst_req_n = 1'b1;
    tick(3);
    chk("R6 err cleared by valid reset", short_err, 1'b0);
    tick(HOLD_C);
    chk("R6 ready back", ready, 1'b1);
  endtask

  task automatic t_ee_boundary();
    tick(EE_C - 1 - since_pg);
    chk("R8 eeprom locked at EE_C-1", eeprom_wr_enable, 1'b0);
    tick(1);
    chk("R8 eeprom open at EE_C", eeprom_wr_enable, 1'b1);
    warm(WARM_C, 1'b0);
    chk("R8 lockout not restarted by reset", eeprom_wr_enable, 1'b1);
  endtask

  task automatic t_power_cycle();
    pwr_good = 1'b0;
    rst_req_n = 1'b0;
    tick(3);
    power_up(40);                  // 42 samples: fine for warm, short for power-on
    tick(3);
    chk("R2 power-on rule after power cycle", short_err, 1'b1);
    rst_req_n = 1'b0;
    tick(POR_C);
    rst_req_n = 1'b1;
    tick(3 + HOLD_C);
    chk("R2 valid por after fault", ready, 1'b1);
    chk("R8 lockout restarted by power cycle", eeprom_wr_enable, 1'b0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_por_short();
    t_por_exact();
    t_gates();
    t_warm_and_recover();
    t_ee_boundary();
    t_power_cycle();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule